// File: doc/BRIEF.md
# Snoopy Cache-Block Coherence State Controller

This block holds the coherence rules for one cache block in a bus-snooping multiprocessor. One engine, built from lookup logic, covers four protocol families, picked by a parameter: three-state (M/S/I), three-state with a clean-exclusive state (M/E/S/I), three-state with a dirty-shared owner (M/O/S/I), and the full five-state set (M/O/E/S/I). The cache controller around the block handles tag lookup, data storage and the miss buffers. It asks this block three kinds of question:

- Which bus command a processor access must issue.
- Which state a fill response leaves the block in.
- What a snooped bus command does to a block the cache holds. The answer covers the new state, whether to drive data, and whether to raise the shared line.

The coherence state sits in the low three bits of a wider status word. Bit 0 means valid, bit 1 means writable and bit 2 means dirty. Every bit above these passes through untouched. A second parameter chooses how a write to a shared copy gains ownership: by an upgrade command or by a full exclusive read. A bank of saturating event counters records accepted processor requests and snoops, one counter for each pair of state and command.

Top module: `coh_state_ctrl`

## Requirements
- R1: Encodings: status I=000, S=001, E=011, O=101, M=111 (bits dirty,writable,valid). Commands: Read=0, Write=1, SoftPrefetch=2, HwPrefetch=3, ReadExcl=4, Upgrade=5, Invalidate=6, WriteInvalidate=7, Writeback=8. A Read or either prefetch on I issues bus Read (0). A Write on I issues ReadExcl (4). A Writeback on any legal state issues Writeback (8).
- R2: A Write on S, or on O in the owner variants (PROTO 2 and 3), issues Upgrade (5) when UPGRADES=1 and ReadExcl (4) when UPGRADES=0.
- R3: A Read response on I gives S when PROTO is 0 (MSI) or 2 (MOSI). When PROTO is 1 (MESI) or 3 (MOESI) it gives E, or S when the shared flag came with the response.
- R4: A ReadExcl response on I, S or a legal O gives M. An Upgrade response on S or a legal O gives M when UPGRADES=1.
- R5: Status bits above bit 2 come out unchanged from every response and snoop lookup.
- R6: A snooped Read on M drives data and raises the shared line. The block goes to S in PROTO 0/1 and to O in PROTO 2/3. A snooped Read on O drives data, raises shared and stays in O.
- R7: A snooped Read on S raises shared and keeps S in every variant except PROTO 0, where nothing happens. A snooped Read on E raises shared and goes to S.
- R8: A snooped ReadExcl moves S/E to I with no data and M/O to I with data. A snooped Upgrade (legal only when UPGRADES=1) moves S/O to I. A snooped Read, ReadExcl or Upgrade on I does nothing.
- R9: A snooped Invalidate or WriteInvalidate moves any legal state to I. A snooped Writeback leaves the state as it is. A snoop with the block-present flag low does nothing and flags no error.
- R10: Each port raises its error flag for an undefined pair, for a state the variant lacks, or for a command code of 9 or above. While the flag is high, the status comes out unchanged, the bus command is 15, and the data and shared outputs stay low.
- R11: cfg_err is high exactly when an owner variant (PROTO 2/3) is built with UPGRADES=0.
- R12: On every clock edge with a valid, error-free request, the request counter for that (state, command) pair increases by one. The same holds for a valid snoop with the block present and no error, using the snoop counter. Responses, errored events and snoops to an absent block are not counted.
- R13: Counters hold at all-ones instead of wrapping. A synchronous reset clears every counter to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, clears the counters |
| req_valid | input | 1 | A processor request is presented this cycle (used for counting) |
| req_cmd | input | 4 | Processor command code |
| req_status | input | STATUS_W | Current block status for the request |
| req_bus_cmd | output | 4 | Bus command to issue, 15 on error |
| req_err | output | 1 | Request pair undefined |
| rsp_cmd | input | 4 | Command the fill response answers |
| rsp_shared | input | 1 | Shared line seen with the response |
| rsp_status | input | STATUS_W | Block status before the fill |
| rsp_new_status | output | STATUS_W | Block status after the fill |
| rsp_err | output | 1 | Response pair undefined |
| snp_valid | input | 1 | A snoop is presented this cycle (used for counting) |
| snp_cmd | input | 4 | Snooped bus command |
| snp_present | input | 1 | The cache holds the snooped block |
| snp_status | input | STATUS_W | Block status before the snoop |
| snp_new_status | output | STATUS_W | Block status after the snoop |
| snp_supply | output | 1 | This cache drives the data |
| snp_shared_out | output | 1 | Raise the shared line |
| snp_err | output | 1 | Snoop pair undefined |
| cfg_err | output | 1 | Illegal parameter combination |
| cnt_snoop | input | 1 | Counter select: 1 snoop bank, 0 request bank |
| cnt_state | input | 3 | Counter select: coherence state code |
| cnt_cmd | input | 4 | Counter select: command code |
| cnt_value | output | CNT_W | Selected counter value, 0 for a command code of 9 or above |

## Verification
The hardest thing to reach from the ports is a counter at its limit. With the default 32-bit width this cannot be reached in a simulation run, so the bench builds the block with 4-bit counters. It then holds a counted request for more cycles than the counter can hold and expects it to stay at 15. A second hard case is telling events that are not counted apart from events that are. The bench holds an errored request and an absent-block snoop valid for several cycles, checks that their counters still read zero, and then checks that one legal snoop moves its counter to exactly one. The table-driven part runs every defined and several undefined transitions of the five-state variant, with and without bits above the coherence field. Separate instances cover the three-state variant without upgrades and the illegal owner-without-upgrade build.

// File: rtl/coh_pkg.sv
package coh_pkg;

    localparam int COH_W    = 3;
    localparam int CMD_W    = 4;
    localparam int NUM_CMDS = 9;

    typedef logic [CMD_W-1:0] cmd_t;
    typedef logic [COH_W-1:0] coh_t;

    localparam cmd_t CMD_READ  = 4'd0;
    localparam cmd_t CMD_WRITE = 4'd1;
    localparam cmd_t CMD_SWPF  = 4'd2;
    localparam cmd_t CMD_HWPF  = 4'd3;
    localparam cmd_t CMD_RDEX  = 4'd4;
    localparam cmd_t CMD_UPG   = 4'd5;
    localparam cmd_t CMD_INV   = 4'd6;
    localparam cmd_t CMD_WRINV = 4'd7;
    localparam cmd_t CMD_WB    = 4'd8;
    localparam cmd_t CMD_NONE  = 4'hF;

    // bit0 valid, bit1 writable, bit2 dirty
    localparam coh_t ST_I = 3'b000;
    localparam coh_t ST_S = 3'b001;
    localparam coh_t ST_E = 3'b011;
    localparam coh_t ST_O = 3'b101;
    localparam coh_t ST_M = 3'b111;

    function automatic logic state_ok(input coh_t st, input logic has_e, input logic has_o);
        case (st)
            ST_I, ST_S, ST_M: state_ok = 1'b1;
            ST_E:             state_ok = has_e;
            ST_O:             state_ok = has_o;
            default:          state_ok = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/coh_req_map.sv
module coh_req_map
    import coh_pkg::*;
#(
    parameter bit HAS_E    = 1'b1,
    parameter bit HAS_O    = 1'b1,
    parameter bit UPGRADES = 1'b1
) (
    input  cmd_t cmd,
    input  coh_t st,
    output cmd_t bus_cmd,
    output logic err
);
    localparam cmd_t OWN_CMD = UPGRADES ? CMD_UPG : CMD_RDEX;

    cmd_t pick;
    logic bad;

    always_comb begin
        pick = CMD_NONE;
        bad  = 1'b0;
        if (!state_ok(st, HAS_E, HAS_O)) begin
            bad = 1'b1;
        end else begin
            case (cmd)
                CMD_READ, CMD_SWPF, CMD_HWPF: begin
                    if (st == ST_I) pick = CMD_READ;
                    else            bad  = 1'b1;
                end
                CMD_WRITE: begin
                    if (st == ST_I)                      pick = CMD_RDEX;
                    else if (st == ST_S || st == ST_O)   pick = OWN_CMD;
                    else                                 bad  = 1'b1;
                end
                CMD_WB:  pick = CMD_WB;
                default: bad  = 1'b1;
            endcase
        end
        bus_cmd = bad ? CMD_NONE : pick;
        err     = bad;
    end
endmodule

// File: rtl/coh_rsp_map.sv
module coh_rsp_map
    import coh_pkg::*;
#(
    parameter int STATUS_W = 8,
    parameter bit HAS_E    = 1'b1,
    parameter bit HAS_O    = 1'b1,
    parameter bit UPGRADES = 1'b1
) (
    input  cmd_t                cmd,
    input  logic                shared_in,
    input  logic [STATUS_W-1:0] old_status,
    output logic [STATUS_W-1:0] new_status,
    output logic                err
);
    coh_t st;
    coh_t nxt;
    logic bad;

    always_comb begin
        st  = old_status[COH_W-1:0];
        nxt = st;
        bad = 1'b0;
        if (!state_ok(st, HAS_E, HAS_O)) begin
            bad = 1'b1;
        end else begin
            case (cmd)
                CMD_READ: begin
                    if (st == ST_I) nxt = (HAS_E && !shared_in) ? ST_E : ST_S;
                    else            bad = 1'b1;
                end
                CMD_RDEX: begin
                    if (st == ST_I || st == ST_S || st == ST_O) nxt = ST_M;
                    else                                         bad = 1'b1;
                end
                CMD_UPG: begin
                    if (UPGRADES && (st == ST_S || st == ST_O)) nxt = ST_M;
                    else                                         bad = 1'b1;
                end
                default: bad = 1'b1;
            endcase
        end
        new_status = old_status;
        if (!bad) new_status[COH_W-1:0] = nxt;
        err = bad;
    end
endmodule

// File: rtl/coh_snp_map.sv
module coh_snp_map
    import coh_pkg::*;
#(
    parameter int STATUS_W = 8,
    parameter bit HAS_E    = 1'b1,
    parameter bit HAS_O    = 1'b1,
    parameter bit UPGRADES = 1'b1
) (
    input  cmd_t                cmd,
    input  logic                present,
    input  logic [STATUS_W-1:0] old_status,
    output logic [STATUS_W-1:0] new_status,
    output logic                supply,
    output logic                shared_out,
    output logic                err
);
    // plain three-state variant never raises shared from a clean copy
    localparam bit SHARE_CLEAN = HAS_E || HAS_O;

    coh_t st;
    coh_t nxt;
    logic sup, shr, bad;

    always_comb begin
        st  = old_status[COH_W-1:0];
        nxt = st;
        sup = 1'b0;
        shr = 1'b0;
        bad = 1'b0;
        if (present) begin
            if (!state_ok(st, HAS_E, HAS_O)) begin
                bad = 1'b1;
            end else begin
                case (cmd)
                    CMD_READ: begin
                        case (st)
                            ST_S: shr = SHARE_CLEAN;
                            ST_E: begin shr = 1'b1; nxt = ST_S; end
                            ST_M: begin sup = 1'b1; shr = 1'b1; nxt = HAS_O ? ST_O : ST_S; end
                            ST_O: begin sup = 1'b1; shr = 1'b1; end
                            default: ;
                        endcase
                    end
                    CMD_RDEX: begin
                        sup = (st == ST_M) || (st == ST_O);
                        nxt = ST_I;
                    end
                    CMD_UPG: begin
                        if (!UPGRADES || st == ST_E || st == ST_M) bad = 1'b1;
                        else                                       nxt = ST_I;
                    end
                    CMD_INV, CMD_WRINV: nxt = ST_I;
                    CMD_WB:             ;
                    default:            bad = 1'b1;
                endcase
            end
        end
        new_status = old_status;
        if (!bad) new_status[COH_W-1:0] = nxt;
        supply     = sup && !bad;
        shared_out = shr && !bad;
        err        = bad;
    end
endmodule

// File: rtl/coh_ctr_bank.sv
module coh_ctr_bank
    import coh_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_hit,
    input  coh_t             req_st,
    input  cmd_t             req_cmd,
    input  logic             snp_hit,
    input  coh_t             snp_st,
    input  cmd_t             snp_cmd,
    input  logic             rd_snoop,
    input  coh_t             rd_st,
    input  cmd_t             rd_cmd,
    output logic [CNT_W-1:0] rd_value
);
    localparam int NSLOT = (1 << COH_W) * NUM_CMDS;
    localparam int IDX_W = $clog2(NSLOT);

    typedef struct packed {
        logic [NSLOT-1:0][CNT_W-1:0] req;
        logic [NSLOT-1:0][CNT_W-1:0] snp;
    } ctr_t;

    ctr_t ctr_d, ctr_q;
    logic [IDX_W-1:0] req_idx, snp_idx, rd_idx;

    function automatic logic [IDX_W-1:0] slot(input coh_t st, input cmd_t cmd);
        slot = IDX_W'(st) * IDX_W'(NUM_CMDS) + IDX_W'(cmd);
    endfunction

    always_comb begin
        req_idx = slot(req_st, req_cmd);
        snp_idx = slot(snp_st, snp_cmd);
        rd_idx  = slot(rd_st, rd_cmd);
        ctr_d   = ctr_q;
        if (req_hit && req_cmd < CMD_W'(NUM_CMDS) && ctr_q.req[req_idx] != '1)
            ctr_d.req[req_idx] = ctr_q.req[req_idx] + CNT_W'(1);
        if (snp_hit && snp_cmd < CMD_W'(NUM_CMDS) && ctr_q.snp[snp_idx] != '1)
            ctr_d.snp[snp_idx] = ctr_q.snp[snp_idx] + CNT_W'(1);
        if (rd_cmd >= CMD_W'(NUM_CMDS)) rd_value = '0;
        else if (rd_snoop)              rd_value = ctr_q.snp[rd_idx];
        else                            rd_value = ctr_q.req[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) ctr_q <= '0;
        else     ctr_q <= ctr_d;
    end
endmodule

// File: rtl/coh_state_ctrl.sv
module coh_state_ctrl
    import coh_pkg::*;
#(
    parameter int PROTO    = 3,
    parameter bit UPGRADES = 1'b1,
    parameter int STATUS_W = 8,
    parameter int CNT_W    = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [3:0]          req_cmd,
    input  logic [STATUS_W-1:0] req_status,
    output logic [3:0]          req_bus_cmd,
    output logic                req_err,
    input  logic [3:0]          rsp_cmd,
    input  logic                rsp_shared,
    input  logic [STATUS_W-1:0] rsp_status,
    output logic [STATUS_W-1:0] rsp_new_status,
    output logic                rsp_err,
    input  logic                snp_valid,
    input  logic [3:0]          snp_cmd,
    input  logic                snp_present,
    input  logic [STATUS_W-1:0] snp_status,
    output logic [STATUS_W-1:0] snp_new_status,
    output logic                snp_supply,
    output logic                snp_shared_out,
    output logic                snp_err,
    output logic                cfg_err,
    input  logic                cnt_snoop,
    input  logic [2:0]          cnt_state,
    input  logic [3:0]          cnt_cmd,
    output logic [CNT_W-1:0]    cnt_value
);
    localparam bit HAS_E   = (PROTO == 1) || (PROTO == 3);
    localparam bit HAS_O   = (PROTO == 2) || (PROTO == 3);
    localparam bit BAD_CFG = HAS_O && !UPGRADES;

    logic req_hit, snp_hit;

    assign cfg_err = BAD_CFG;

    coh_req_map #(.HAS_E(HAS_E), .HAS_O(HAS_O), .UPGRADES(UPGRADES)) u_req (
        .cmd     (req_cmd),
        .st      (req_status[COH_W-1:0]),
        .bus_cmd (req_bus_cmd),
        .err     (req_err)
    );

    coh_rsp_map #(.STATUS_W(STATUS_W), .HAS_E(HAS_E), .HAS_O(HAS_O),
                  .UPGRADES(UPGRADES)) u_rsp (
        .cmd        (rsp_cmd),
        .shared_in  (rsp_shared),
        .old_status (rsp_status),
        .new_status (rsp_new_status),
        .err        (rsp_err)
    );

    coh_snp_map #(.STATUS_W(STATUS_W), .HAS_E(HAS_E), .HAS_O(HAS_O),
                  .UPGRADES(UPGRADES)) u_snp (
        .cmd        (snp_cmd),
        .present    (snp_present),
        .old_status (snp_status),
        .new_status (snp_new_status),
        .supply     (snp_supply),
        .shared_out (snp_shared_out),
        .err        (snp_err)
    );

    assign req_hit = req_valid && !req_err;
    assign snp_hit = snp_valid && snp_present && !snp_err;

    coh_ctr_bank #(.CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .req_hit  (req_hit),
        .req_st   (req_status[COH_W-1:0]),
        .req_cmd  (req_cmd),
        .snp_hit  (snp_hit),
        .snp_st   (snp_status[COH_W-1:0]),
        .snp_cmd  (snp_cmd),
        .rd_snoop (cnt_snoop),
        .rd_st    (cnt_state),
        .rd_cmd   (cnt_cmd),
        .rd_value (cnt_value)
    );
endmodule

// File: rtl/coh_state_ctrl_chk.sv
module coh_state_ctrl_chk #(
    parameter int STATUS_W = 8,
    parameter int CNT_W    = 32
) (
    input logic                clk,
    input logic                rst,
    input logic [3:0]          req_bus_cmd,
    input logic                req_err,
    input logic [3:0]          rsp_cmd,
    input logic [STATUS_W-1:0] rsp_status,
    input logic [STATUS_W-1:0] rsp_new_status,
    input logic                rsp_err,
    input logic                snp_present,
    input logic [STATUS_W-1:0] snp_status,
    input logic [STATUS_W-1:0] snp_new_status,
    input logic                snp_supply,
    input logic                snp_shared_out,
    input logic                snp_err,
    input logic                cnt_snoop,
    input logic [2:0]          cnt_state,
    input logic [3:0]          cnt_cmd,
    input logic [CNT_W-1:0]    cnt_value
);
    // R10
    rsp_err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_new_status == rsp_status);

    // R10
    snp_err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        snp_err |-> (snp_new_status == snp_status && !snp_supply && !snp_shared_out));

    // R10
    req_err_none_chk: assert property (@(posedge clk) disable iff (rst)
        req_err |-> req_bus_cmd == 4'hF);

    // R5
    rsp_upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_new_status >> 3) == (rsp_status >> 3));

    // R5
    snp_upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (snp_new_status >> 3) == (snp_status >> 3));

    // R8
    supply_dirty_chk: assert property (@(posedge clk) disable iff (rst)
        snp_supply |-> (snp_present && snp_status[2] && snp_new_status[2:0] != 3'b111));

    // R9
    absent_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !snp_present |-> (!snp_supply && !snp_shared_out && !snp_err &&
                          snp_new_status == snp_status));

    // R4
    own_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (!rsp_err && (rsp_cmd == 4'd4 || rsp_cmd == 4'd5)) |-> rsp_new_status[2:0] == 3'b111);

    // R13
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(cnt_snoop) && $stable(cnt_state) && $stable(cnt_cmd))
        |-> cnt_value >= $past(cnt_value));
endmodule

bind coh_state_ctrl coh_state_ctrl_chk #(.STATUS_W(STATUS_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_coh_state_ctrl.sv
`timescale 1ns/1ps
module tb_coh_state_ctrl;
    localparam int SW = 4;
    localparam int CW = 4;

    typedef struct packed {
        logic [1:0] port;   // 0 request, 1 response, 2 snoop
        logic [3:0] cmd;
        logic [3:0] st;
        logic       flag;   // shared for response, present for snoop
        logic [3:0] exp;    // bus cmd or new status
        logic       sup;
        logic       shr;
        logic       err;
        logic [3:0] rq;
    } vec_t;

    function automatic vec_t mk(input logic [1:0] p, input logic [3:0] c, input logic [3:0] s,
                                input logic f, input logic [3:0] e, input logic sp,
                                input logic sh, input logic er, input logic [3:0] r);
        mk = '{port: p, cmd: c, st: s, flag: f, exp: e, sup: sp, shr: sh, err: er, rq: r};
    endfunction

    localparam int NV = 34;
    // five-state variant with upgrades
    localparam vec_t VECS [NV] = '{
        mk(0, 0, 4'b0000, 0, 4'd0, 0, 0, 0, 1),   // R1 read on I
        mk(0, 2, 4'b0000, 0, 4'd0, 0, 0, 0, 1),   // R1 soft prefetch
        mk(0, 3, 4'b1000, 0, 4'd0, 0, 0, 0, 1),   // R1 hw prefetch
        mk(0, 1, 4'b0000, 0, 4'd4, 0, 0, 0, 1),   // R1 write on I
        mk(0, 8, 4'b0111, 0, 4'd8, 0, 0, 0, 1),   // R1 writeback
        mk(0, 1, 4'b0001, 0, 4'd5, 0, 0, 0, 2),   // R2 write on S
        mk(0, 1, 4'b0101, 0, 4'd5, 0, 0, 0, 2),   // R2 write on O
        mk(0, 0, 4'b0001, 0, 4'hF, 0, 0, 1, 10),  // R10 read on S undefined
        mk(0, 9, 4'b0000, 0, 4'hF, 0, 0, 1, 10),  // R10 unknown command
        mk(1, 0, 4'b0000, 0, 4'b0011, 0, 0, 0, 3),// R3 read fill alone -> E
        mk(1, 0, 4'b0000, 1, 4'b0001, 0, 0, 0, 3),// R3 read fill shared -> S
        mk(1, 0, 4'b1000, 0, 4'b1011, 0, 0, 0, 5),// R5 upper bit kept
        mk(1, 4, 4'b0000, 0, 4'b0111, 0, 0, 0, 4),// R4 readexcl fill
        mk(1, 5, 4'b1001, 0, 4'b1111, 0, 0, 0, 4),// R4 upgrade fill from S
        mk(1, 5, 4'b0101, 0, 4'b0111, 0, 0, 0, 4),// R4 upgrade fill from O
        mk(1, 0, 4'b0001, 0, 4'b0001, 0, 0, 1, 10),// R10 read fill on S
        mk(1, 8, 4'b1011, 0, 4'b1011, 0, 0, 1, 10),// R10 writeback fill
        mk(2, 0, 4'b0111, 1, 4'b0101, 1, 1, 0, 6),// R6 read snoop M -> O
        mk(2, 0, 4'b1101, 1, 4'b1101, 1, 1, 0, 6),// R6 read snoop O stays
        mk(2, 0, 4'b0011, 1, 4'b0001, 0, 1, 0, 7),// R7 read snoop E -> S
        mk(2, 0, 4'b0001, 1, 4'b0001, 0, 1, 0, 7),// R7 read snoop S
        mk(2, 4, 4'b0111, 1, 4'b0000, 1, 0, 0, 8),// R8 readexcl snoop M
        mk(2, 4, 4'b1011, 1, 4'b1000, 0, 0, 0, 8),// R8 readexcl snoop E
        mk(2, 4, 4'b0101, 1, 4'b0000, 1, 0, 0, 8),// R8 readexcl snoop O
        mk(2, 5, 4'b0001, 1, 4'b0000, 0, 0, 0, 8),// R8 upgrade snoop S
        mk(2, 5, 4'b1101, 1, 4'b1000, 0, 0, 0, 8),// R8 upgrade snoop O
        mk(2, 0, 4'b0000, 1, 4'b0000, 0, 0, 0, 8),// R8 read snoop on I
        mk(2, 6, 4'b0111, 1, 4'b0000, 0, 0, 0, 9),// R9 invalidate M
        mk(2, 7, 4'b1011, 1, 4'b1000, 0, 0, 0, 9),// R9 write-invalidate E
        mk(2, 8, 4'b0111, 1, 4'b0111, 0, 0, 0, 9),// R9 writeback snoop
        mk(2, 0, 4'b0111, 0, 4'b0111, 0, 0, 0, 9),// R9 absent block
        mk(2, 5, 4'b0111, 1, 4'b0111, 0, 0, 1, 10),// R10 upgrade snoop on M
        mk(2, 1, 4'b0001, 1, 4'b0001, 0, 0, 1, 10),// R10 write snoop
        mk(2, 0, 4'b0010, 1, 4'b0010, 0, 0, 1, 10) // R10 illegal code
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, rsp_shared = 1'b0, snp_valid = 1'b0, snp_present = 1'b0;
    logic [3:0] req_cmd = '0, rsp_cmd = '0, snp_cmd = '0, cnt_cmd = '0;
    logic [SW-1:0] req_status = '0, rsp_status = '0, snp_status = '0;
    logic cnt_snoop = 1'b0;
    logic [2:0] cnt_state = '0;

    logic [3:0] bus, bus_m, bus_b;
    logic [SW-1:0] rsp_ns, snp_ns, rsp_ns_m, snp_ns_m, rsp_ns_b, snp_ns_b;
    logic req_e, rsp_e, snp_e, sup, shr, cfg;
    logic req_e_m, rsp_e_m, snp_e_m, sup_m, shr_m, cfg_m;
    logic req_e_b, rsp_e_b, snp_e_b, sup_b, shr_b, cfg_b;
    logic [CW-1:0] cval, cval_m, cval_b;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    coh_state_ctrl #(.PROTO(3), .UPGRADES(1'b1), .STATUS_W(SW), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd), .req_status(req_status),
        .req_bus_cmd(bus), .req_err(req_e), .rsp_cmd(rsp_cmd), .rsp_shared(rsp_shared),
        .rsp_status(rsp_status), .rsp_new_status(rsp_ns), .rsp_err(rsp_e),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_present(snp_present),
        .snp_status(snp_status), .snp_new_status(snp_ns), .snp_supply(sup),
        .snp_shared_out(shr), .snp_err(snp_e), .cfg_err(cfg), .cnt_snoop(cnt_snoop),
        .cnt_state(cnt_state), .cnt_cmd(cnt_cmd), .cnt_value(cval));

    coh_state_ctrl #(.PROTO(0), .UPGRADES(1'b0), .STATUS_W(SW), .CNT_W(CW)) dut_msi (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd), .req_status(req_status),
        .req_bus_cmd(bus_m), .req_err(req_e_m), .rsp_cmd(rsp_cmd), .rsp_shared(rsp_shared),
        .rsp_status(rsp_status), .rsp_new_status(rsp_ns_m), .rsp_err(rsp_e_m),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_present(snp_present),
        .snp_status(snp_status), .snp_new_status(snp_ns_m), .snp_supply(sup_m),
        .snp_shared_out(shr_m), .snp_err(snp_e_m), .cfg_err(cfg_m), .cnt_snoop(cnt_snoop),
        .cnt_state(cnt_state), .cnt_cmd(cnt_cmd), .cnt_value(cval_m));

    coh_state_ctrl #(.PROTO(2), .UPGRADES(1'b0), .STATUS_W(SW), .CNT_W(CW)) dut_bad (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd), .req_status(req_status),
        .req_bus_cmd(bus_b), .req_err(req_e_b), .rsp_cmd(rsp_cmd), .rsp_shared(rsp_shared),
        .rsp_status(rsp_status), .rsp_new_status(rsp_ns_b), .rsp_err(rsp_e_b),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_present(snp_present),
        .snp_status(snp_status), .snp_new_status(snp_ns_b), .snp_supply(sup_b),
        .snp_shared_out(shr_b), .snp_err(snp_e_b), .cfg_err(cfg_b), .cnt_snoop(cnt_snoop),
        .cnt_state(cnt_state), .cnt_cmd(cnt_cmd), .cnt_value(cval_b));

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    task automatic sel_cnt(input logic s, input logic [2:0] st, input logic [3:0] c);
        cnt_snoop = s;
        cnt_state = st;
        cnt_cmd   = c;
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        string tag;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R13 reset state
        sel_cnt(1'b0, 3'b000, 4'd0); #1;
        check("R13", "request counter after reset", int'(cval), 0);
        sel_cnt(1'b1, 3'b111, 4'd0); #1;
        check("R13", "snoop counter after reset", int'(cval), 0);

        // R11
        check("R11", "cfg_err five-state", int'(cfg), 0);
        check("R11", "cfg_err three-state", int'(cfg_m), 0);
        check("R11", "cfg_err owner without upgrade", int'(cfg_b), 1);

        // table walk on the five-state build
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            tag = $sformatf("R%0d vec%0d", VECS[i].rq, i);
            case (VECS[i].port)
                2'd0: begin
                    req_cmd = VECS[i].cmd; req_status = VECS[i].st; #1;
                    check(tag, "bus cmd", int'(bus), int'(VECS[i].exp));
                    check(tag, "req err", int'(req_e), int'(VECS[i].err));
                end
                2'd1: begin
                    rsp_cmd = VECS[i].cmd; rsp_status = VECS[i].st; rsp_shared = VECS[i].flag; #1;
                    check(tag, "fill status", int'(rsp_ns), int'(VECS[i].exp));
                    check(tag, "fill err", int'(rsp_e), int'(VECS[i].err));
                end
                default: begin
                    snp_cmd = VECS[i].cmd; snp_status = VECS[i].st; snp_present = VECS[i].flag; #1;
                    check(tag, "snoop status", int'(snp_ns), int'(VECS[i].exp));
                    check(tag, "supply", int'(sup), int'(VECS[i].sup));
                    check(tag, "shared", int'(shr), int'(VECS[i].shr));
                    check(tag, "snoop err", int'(snp_e), int'(VECS[i].err));
                end
            endcase
        end

        // three-state build without upgrades
        @(negedge clk);
        req_cmd = 4'd1; req_status = 4'b0001; #1;
        check("R2", "three-state write on S", int'(bus_m), 4);
        req_cmd = 4'd1; req_status = 4'b0101; #1;
        check("R10", "three-state write on O", int'(bus_m), 15);
        rsp_cmd = 4'd0; rsp_status = 4'b0000; rsp_shared = 1'b0; #1;
        check("R3", "three-state read fill", int'(rsp_ns_m), 1);
        rsp_cmd = 4'd5; rsp_status = 4'b0001; #1;
        check("R4", "three-state upgrade fill err", int'(rsp_e_m), 1);
        snp_present = 1'b1; snp_cmd = 4'd0; snp_status = 4'b0001; #1;
        check("R7", "three-state read snoop S shared", int'(shr_m), 0);
        check("R7", "three-state read snoop S state", int'(snp_ns_m), 1);
        snp_cmd = 4'd0; snp_status = 4'b1111; #1;
        check("R6", "three-state read snoop M state", int'(snp_ns_m), 9);
        check("R6", "three-state read snoop M supply", int'(sup_m), 1);
        check("R6", "three-state read snoop M shared", int'(shr_m), 1);
        snp_cmd = 4'd5; snp_status = 4'b0001; #1;
        check("R8", "three-state upgrade snoop err", int'(snp_e_m), 1);

        // counters on the five-state build
        pulse_reset();
        req_cmd = 4'd0; req_status = 4'b0000; req_valid = 1'b1;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        sel_cnt(1'b0, 3'b000, 4'd0); #1;
        check("R12", "request count read on I", int'(cval), 3);

        req_cmd = 4'd0; req_status = 4'b0001; req_valid = 1'b1;
        repeat (2) @(negedge clk);
        req_valid = 1'b0;
        sel_cnt(1'b0, 3'b001, 4'd0); #1;
        check("R12", "errored request not counted", int'(cval), 0);

        snp_cmd = 4'd0; snp_status = 4'b0111; snp_present = 1'b0; snp_valid = 1'b1;
        repeat (2) @(negedge clk);
        sel_cnt(1'b1, 3'b111, 4'd0); #1;
        check("R12", "absent snoop not counted", int'(cval), 0);
        snp_present = 1'b1;
        @(negedge clk);
        snp_valid = 1'b0; #1;
        check("R12", "present snoop counted", int'(cval), 1);

        req_cmd = 4'd0; req_status = 4'b0000; req_valid = 1'b1;
        repeat (20) @(negedge clk);
        req_valid = 1'b0;
        sel_cnt(1'b0, 3'b000, 4'd0); #1;
        check("R13", "saturated count", int'(cval), 15);

        pulse_reset();
        #1;
        check("R13", "count after second reset", int'(cval), 0);

        @(negedge clk);
        finish_run();
    end
endmodule